// File: doc/BRIEF.md
# Interleaved Configuration Image Header Parser

This block sits on a byte stream that carries several configuration images cut into fixed-size chunks and sent one image after another in rotation. After a start pulse it accepts every byte offered, keeps only the bytes of one chosen image and drops the rest. The kept bytes first have to match a fixed 13-byte file preamble. After that comes a sequence of tagged header sections. The parser walks these sections until it reaches the payload section, which carries the tag 0x65 ('e'). It then reports the payload length and passes the chosen image's remaining bytes straight to its output.

The image is chosen with a 1-based index and a count of interleaved images. Both are sampled on the start pulse and must stay stable for the whole run. Two sanity checks guard the header walk: a limit on the length of ordinary sections, and a budget on the number of header bytes consumed. Either one can end the walk with an error instead of letting it run through payload data. Decompression of the stream is handled upstream and is outside this block.

Top module: `bitstream_hdr_parser`

## Requirements
- R1: After reset and before the first start pulse, `found`, `error`, `in_ready` and `out_valid` are all 0.
- R2: Number every byte accepted since the last start from 0, dropped bytes included. Byte i belongs to the chosen image exactly when floor(i / CHUNK_BYTES) mod `img_count` equals `img_sel` - 1. The default CHUNK_BYTES is 288. Every other byte is accepted and has no effect on parsing or on the output.
- R3: If `img_sel` is 0 or greater than `img_count` when start is sampled, `error` is 1 on the cycle after start, and no byte is accepted.
- R4: The first 13 kept bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 (hex, in stream order). Any byte that differs sets `error`.
- R5: Each header section is a one-byte tag, then a big-endian length, then that many content bytes. The length field is 4 bytes for tag 0x65 and 2 bytes for every other tag.
- R6: A section tag below 0x61 or above 0x65 sets `error`.
- R7: A length above 255 on any section whose tag is not 0x65 sets `error` once the last length byte has been accepted.
- R8: Tag, length and content bytes consumed after the preamble count against a budget of SEARCH_LIMIT bytes (default 100). A new tag is read only while fewer than SEARCH_LIMIT bytes have been consumed. Content skipping stops when the budget is reached. Length bytes may run past the budget. If the budget runs out before tag 0x65 is reached, `error` is set.
- R9: When the last length byte of tag 0x65 is accepted, `found` becomes 1 and `payload_len` holds the full 32-bit length.
- R10: While `found` is 1, each kept byte appears on `out_data` with `out_valid` in the same cycle, and is accepted only when `out_ready` is 1. Dropped bytes are accepted whatever `out_ready` is. Payload bytes leave in stream order.
- R11: `found` and `error` are never both 1. Each stays set, and `payload_len` stays unchanged, until the next start pulse. While `error` is 1, `in_ready` is 0.
- R12: A start pulse clears both flags and all counters and begins a new parse. `in_ready` is 0 during the start cycle, so a byte offered in that cycle is not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle pulse that begins a new parse |
| img_sel | input | IDX_W | Chosen image, 1-based |
| img_count | input | IDX_W | Number of interleaved images |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| found | output | 1 | Payload section reached (sticky) |
| error | output | 1 | Parse failed (sticky) |
| payload_len | output | 32 | Length field of the payload section |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Downstream accepts the payload byte |

## Verification
Two functions can act in the same cycle: the chunk rotation, which decides whether a byte is kept, and the header walker's step on the last byte of a field. A stage change can also coincide with a start pulse that arrives with a valid byte. The bench provokes the first case with a small chunk size, so the preamble, the section fields and the payload all straddle chunk boundaries. It sweeps every image count and index of a small configuration, with backpressure on some runs. It provokes the start collision by holding a valid first preamble byte during the start cycle. Each run is judged by computing the kept and dropped positions arithmetically and comparing the flags, the reported length and the order of the payload bytes against them. A byte taken at the wrong point would misalign the preamble check or the payload order.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

  localparam int BYTE_W    = 8;
  localparam int LEN_W     = 32;
  localparam int PRE_LEN   = 13;
  localparam int PRE_IDX_W = 4;
  localparam logic [7:0] TAG_FIRST   = 8'h61;
  localparam logic [7:0] TAG_LAST    = 8'h65;
  localparam logic [7:0] TAG_PAYLOAD = 8'h65;
  localparam logic [LEN_W-1:0] SHORT_LEN_MAX = 32'd255;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_WALK,
    ST_BODY,
    ST_FAIL
  } top_state_t;

  typedef enum logic [1:0] {
    WK_TAG,
    WK_LEN,
    WK_SKIP
  } walk_state_t;

  // Expected preamble byte at a given position; computed, not tabulated.
  function automatic logic [7:0] preamble_byte(input logic [PRE_IDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0, 4'd10, 4'd11: b = 8'h00;
      4'd1:               b = 8'h09;
      4'd12:              b = 8'h01;
      default:            b = idx[0] ? 8'hF0 : 8'h0F;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bhp_chunk_sel.sv
module bhp_chunk_sel #(
  parameter int CHUNK_BYTES = 288,
  parameter int IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [IDX_W-1:0] img_sel,
  input  logic [IDX_W-1:0] img_count,
  output logic             keep
);

  localparam int POS_W = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(CHUNK_BYTES - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [IDX_W-1:0] slot_q, slot_d;
  logic             pos_en;

  assign keep   = (slot_q == (img_sel - IDX_W'(1)));
  assign pos_en = clear | advance;

  always_comb begin
    pos_d  = pos_q;
    slot_d = slot_q;
    if (clear) begin
      pos_d  = '0;
      slot_d = '0;
    end else if (advance) begin
      if (pos_q == POS_LAST) begin
        pos_d  = '0;
        slot_d = (slot_q == (img_count - IDX_W'(1))) ? '0 : slot_q + IDX_W'(1);
      end else begin
        pos_d = pos_q + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      slot_q <= '0;
    end else if (pos_en) begin
      pos_q  <= pos_d;
      slot_q <= slot_d;
    end
  end

  a_r2_pos_in_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_LAST);

  a_r2_chunk_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear && pos_q == POS_LAST) |=> (pos_q == '0));

endmodule

// File: rtl/bhp_preamble_chk.sv
module bhp_preamble_chk
  import bhp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [BYTE_W-1:0] data,
  output logic              mismatch,
  output logic              last
);

  logic [PRE_IDX_W-1:0] idx_q, idx_d;
  logic                 idx_en;

  assign mismatch = (data != preamble_byte(idx_q));
  assign last     = (idx_q == PRE_IDX_W'(PRE_LEN - 1));
  assign idx_en   = clear | advance;

  always_comb begin
    idx_d = idx_q;
    if (clear)                  idx_d = '0;
    else if (advance && !last)  idx_d = idx_q + PRE_IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  a_r4_index_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= PRE_IDX_W'(PRE_LEN - 1));

endmodule

// File: rtl/bhp_section_walk.sv
module bhp_section_walk
  import bhp_pkg::*;
#(
  parameter int SEARCH_LIMIT = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [BYTE_W-1:0] data,
  output logic              stall,
  output logic              hit,
  output logic              abort,
  output logic [LEN_W-1:0]  hit_len
);

  localparam int BUD_W = $clog2(SEARCH_LIMIT + 1);
  localparam logic [BUD_W-1:0] BUD_MAX = BUD_W'(SEARCH_LIMIT);

  walk_state_t       w_q, w_d;
  logic              is_pay_q, is_pay_d;
  logic [1:0]        left_q, left_d;
  logic [LEN_W-1:0]  acc_q, acc_d;
  logic [7:0]        skip_q, skip_d;
  logic [BUD_W-1:0]  bud_q, bud_d;
  logic              spent, tag_bad;
  logic [LEN_W-1:0]  acc_shift;

  assign spent     = (bud_q >= BUD_MAX);
  assign stall     = spent && (w_q != WK_LEN);
  assign tag_bad   = (data < TAG_FIRST) || (data > TAG_LAST);
  assign acc_shift = {acc_q[LEN_W-9:0], data};
  assign hit_len   = acc_shift;

  always_comb begin
    w_d      = w_q;
    is_pay_d = is_pay_q;
    left_d   = left_q;
    acc_d    = acc_q;
    skip_d   = skip_q;
    bud_d    = bud_q;
    hit      = 1'b0;
    abort    = 1'b0;
    if (advance && !spent) bud_d = bud_q + BUD_W'(1);
    unique case (w_q)
      WK_TAG: begin
        if (spent) begin
          abort = 1'b1;
        end else if (advance) begin
          if (tag_bad) begin
            abort = 1'b1;
          end else begin
            is_pay_d = (data == TAG_PAYLOAD);
            left_d   = (data == TAG_PAYLOAD) ? 2'd3 : 2'd1;
            acc_d    = '0;
            w_d      = WK_LEN;
          end
        end
      end
      WK_LEN: begin
        if (advance) begin
          acc_d = acc_shift;
          if (left_q == 2'd0) begin
            if (!is_pay_q && acc_shift > SHORT_LEN_MAX) begin
              abort = 1'b1;
            end else if (is_pay_q) begin
              hit = 1'b1;
            end else if (acc_shift == '0) begin
              w_d = WK_TAG;
            end else begin
              skip_d = acc_shift[7:0];
              w_d    = WK_SKIP;
            end
          end else begin
            left_d = left_q - 2'd1;
          end
        end
      end
      WK_SKIP: begin
        if (spent) begin
          w_d = WK_TAG;
        end else if (advance) begin
          skip_d = skip_q - 8'd1;
          if (skip_q == 8'd1) w_d = WK_TAG;
        end
      end
      default: w_d = WK_TAG;
    endcase
    if (clear) begin
      w_d      = WK_TAG;
      is_pay_d = 1'b0;
      left_d   = '0;
      acc_d    = '0;
      skip_d   = '0;
      bud_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q      <= WK_TAG;
      is_pay_q <= 1'b0;
      left_q   <= '0;
      acc_q    <= '0;
      skip_q   <= '0;
      bud_q    <= '0;
    end else begin
      w_q      <= w_d;
      is_pay_q <= is_pay_d;
      left_q   <= left_d;
      acc_q    <= acc_d;
      skip_q   <= skip_d;
      bud_q    <= bud_d;
    end
  end

  a_r8_budget_capped: assert property (@(posedge clk) disable iff (!rst_n)
    bud_q <= BUD_MAX);

  a_r8_no_take_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
    (spent && w_q != WK_LEN) |-> !advance);

  a_r6_hit_abort_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && abort));

endmodule

// File: rtl/bitstream_hdr_parser.sv
module bitstream_hdr_parser
  import bhp_pkg::*;
#(
  parameter int CHUNK_BYTES  = 288,
  parameter int IDX_W        = 3,
  parameter int SEARCH_LIMIT = 100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [IDX_W-1:0]      img_sel,
  input  logic [IDX_W-1:0]      img_count,
  input  logic                  in_valid,
  input  logic [BYTE_W-1:0]     in_data,
  output logic                  in_ready,
  output logic                  found,
  output logic                  error,
  output logic [LEN_W-1:0]      payload_len,
  output logic                  out_valid,
  output logic [BYTE_W-1:0]     out_data,
  input  logic                  out_ready
);

  top_state_t       st_q, st_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             len_en;
  logic             keep, hs, sel_ok;
  logic             pre_adv, pre_bad, pre_last;
  logic             walk_adv, walk_stall, walk_hit, walk_abort;
  logic [LEN_W-1:0] walk_len;

  assign sel_ok = (img_sel != '0) && (img_sel <= img_count);

  bhp_chunk_sel #(
    .CHUNK_BYTES (CHUNK_BYTES),
    .IDX_W       (IDX_W)
  ) chunk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .advance   (hs),
    .img_sel   (img_sel),
    .img_count (img_count),
    .keep      (keep)
  );

  bhp_preamble_chk pre_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .advance  (pre_adv),
    .data     (in_data),
    .mismatch (pre_bad),
    .last     (pre_last)
  );

  bhp_section_walk #(
    .SEARCH_LIMIT (SEARCH_LIMIT)
  ) walk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .advance (walk_adv),
    .data    (in_data),
    .stall   (walk_stall),
    .hit     (walk_hit),
    .abort   (walk_abort),
    .hit_len (walk_len)
  );

  always_comb begin
    in_ready = 1'b0;
    if (!start) begin
      unique case (st_q)
        ST_PRE:  in_ready = 1'b1;
        ST_WALK: in_ready = keep ? !walk_stall : 1'b1;
        ST_BODY: in_ready = keep ? out_ready : 1'b1;
        default: in_ready = 1'b0;
      endcase
    end
  end

  assign hs        = in_valid && in_ready;
  assign pre_adv   = hs && keep && (st_q == ST_PRE);
  assign walk_adv  = hs && keep && (st_q == ST_WALK);
  assign out_valid = (st_q == ST_BODY) && in_valid && keep;
  assign out_data  = in_data;

  always_comb begin
    st_d   = st_q;
    len_d  = len_q;
    len_en = 1'b0;
    if (start) begin
      st_d   = sel_ok ? ST_PRE : ST_FAIL;
      len_d  = '0;
      len_en = 1'b1;
    end else begin
      unique case (st_q)
        ST_PRE: begin
          if (pre_adv) begin
            if (pre_bad)       st_d = ST_FAIL;
            else if (pre_last) st_d = ST_WALK;
          end
        end
        ST_WALK: begin
          if (walk_abort) begin
            st_d = ST_FAIL;
          end else if (walk_hit) begin
            st_d   = ST_BODY;
            len_d  = walk_len;
            len_en = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= len_d;
  end

  assign found       = (st_q == ST_BODY);
  assign error       = (st_q == ST_FAIL);
  assign payload_len = len_q;

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && error));

  a_r11_found_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !start) |=> found);

  a_r11_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  a_r11_error_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !in_ready);

  a_r11_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !start) |=> $stable(payload_len));

  a_r10_output_needs_found: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> found);

  a_r12_start_takes_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_ready);

  a_r3_bad_selection: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sel_ok) |=> error);

endmodule

// File: tb/bitstream_hdr_parser_tb_top.sv
module bitstream_hdr_parser_tb_top;

  localparam int CHUNK = 8;
  localparam int IW    = 3;
  localparam int LIMIT = 100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [IW-1:0] img_sel, img_count;
  logic          in_valid;
  logic [7:0]    in_data;
  logic          in_ready, found, error, out_valid, out_ready;
  logic [31:0]   payload_len;
  logic [7:0]    out_data;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic [7:0] img [0:1023];
  int img_len = 0;
  int hdr_len = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitstream_hdr_parser #(
    .CHUNK_BYTES  (CHUNK),
    .IDX_W        (IW),
    .SEARCH_LIMIT (LIMIT)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .img_sel     (img_sel),
    .img_count   (img_count),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .found       (found),
    .error       (error),
    .payload_len (payload_len),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_ready   (out_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pre_ref(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h09;  2: return 8'h0F;  3: return 8'hF0;
      4: return 8'h0F;  5: return 8'hF0;  6: return 8'h0F;  7: return 8'hF0;
      8: return 8'h0F;  9: return 8'hF0; 10: return 8'h00; 11: return 8'h00;
      default: return 8'h01;
    endcase
  endfunction

  task automatic put(input logic [7:0] b);
    img[img_len] = b;
    img_len++;
  endtask

  task automatic put_pre();
    img_len = 0;
    for (int i = 0; i < 13; i++) put(pre_ref(i));
  endtask

  task automatic put_sec(input logic [7:0] tag, input int len);
    put(tag);
    put(8'((len >> 8) & 255));
    put(8'(len & 255));
    for (int i = 0; i < len; i++) put(8'(8'h20 + i));
  endtask

  task automatic put_pay(input logic [31:0] len, input int npay);
    put(8'h65);
    put(len[31:24]); put(len[23:16]); put(len[15:8]); put(len[7:0]);
    hdr_len = img_len;
    for (int i = 0; i < npay; i++) put(8'(8'h80 ^ (i * 7)));
  endtask

  function automatic bit mine(input int g, input int cnt, input int sel);
    return ((g / CHUNK) % cnt) == (sel - 1);
  endfunction

  task automatic run(input int cnt, input int sel, input bit exp_found,
                     input logic [31:0] exp_len, input bit bp, input bit collide,
                     input string req);
    int g, loc, k, stalls;
    bit took, sel_ok;
    sel_ok = (sel >= 1) && (sel <= cnt);
    @(negedge clk);
    img_count = IW'(cnt);
    img_sel   = IW'(sel);
    start     = 1'b1;
    in_valid  = collide;
    in_data   = img[0];
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R12 ready low on start", 32'(in_ready), 0);
    @(posedge clk);
    #1;
    start = 1'b0;
    if (sel_ok) chk(!found && !error, "R12 flags cleared", {30'd0, found, error}, 0);
    else        chk(error == 1'b1, "R3 bad selection error", 32'(error), 1);
    g = 0; loc = 0; k = 0; stalls = 0;
    while (loc < img_len && !error && stalls < 3000) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = mine(g, cnt, sel) ? img[loc] : 8'(8'hC3 ^ g);
      out_ready = bp ? ((cyc % 3) != 0) : 1'b1;
      #1;
      took = in_ready;
      if (out_valid && out_ready) begin
        if (hdr_len + k < img_len)
          chk(out_data == img[hdr_len + k], "R10 payload byte", 32'(out_data), 32'(img[hdr_len + k]));
        else
          chk(1'b0, "R10 extra payload byte", 32'(k), 32'(img_len - hdr_len));
        k++;
      end
      @(posedge clk);
      if (took) begin
        if (mine(g, cnt, sel)) loc++;
        g++;
        stalls = 0;
      end else begin
        stalls++;
      end
    end
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h00;
    #1;
    chk(found == exp_found, {req, " found"}, 32'(found), 32'(exp_found));
    chk(error == !exp_found, {req, " error"}, 32'(error), 32'(!exp_found));
    if (exp_found) begin
      chk(payload_len == exp_len, "R9 payload length", payload_len, exp_len);
      chk(k == img_len - hdr_len, "R10 payload count", 32'(k), 32'(img_len - hdr_len));
    end else begin
      chk(in_ready == 1'b0, "R11 input blocked after error", 32'(in_ready), 0);
      chk(k == 0, "R11 no output after error", 32'(k), 0);
    end
    in_valid = 1'b0;
  endtask

  task automatic good_image(input int npay);
    put_pre();
    put_sec(8'h61, 3);
    put_sec(8'h63, 0);
    put_sec(8'h64, 1);
    put_pay(32'(npay), npay);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0;
    out_ready = 1'b1; img_sel = '0; img_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b1;
    #1;
    // R1: idle state after reset
    chk(!found && !error, "R1 flags idle", {30'd0, found, error}, 0);
    chk(!in_ready && !out_valid, "R1 handshake idle", {30'd0, in_ready, out_valid}, 0);
    in_valid = 1'b0;

    // R2, R5, R9, R10: sweep every count and index
    for (int c = 1; c <= 4; c++) begin
      for (int s = 1; s <= c; s++) begin
        good_image(20);
        run(c, s, 1'b1, 32'd20, ((c + s) % 2) == 1, 1'b0, "R2 interleave");
      end
    end

    // R3: selections out of range
    good_image(4);
    run(2, 0, 1'b0, 0, 1'b0, 1'b0, "R3 index zero");
    run(2, 3, 1'b0, 0, 1'b0, 1'b0, "R3 index above count");

    // R4: corrupt each preamble position
    for (int p = 0; p < 13; p++) begin
      good_image(4);
      img[p] = img[p] ^ 8'h40;
      hdr_len = img_len;
      run(2, 2, 1'b0, 0, 1'b0, 1'b0, "R4 preamble mismatch");
    end

    // R6: tags outside range
    put_pre(); put_sec(8'h66, 1); put_pay(32'd2, 2); hdr_len = img_len;
    run(1, 1, 1'b0, 0, 1'b0, 1'b0, "R6 tag above range");
    put_pre(); put_sec(8'h60, 1); put_pay(32'd2, 2); hdr_len = img_len;
    run(3, 1, 1'b0, 0, 1'b0, 1'b0, "R6 tag below range");

    // R7: short-length limit, and long length allowed on payload tag (R5)
    put_pre(); put(8'h61); put(8'h01); put(8'h00); hdr_len = img_len;
    run(2, 1, 1'b0, 0, 1'b0, 1'b0, "R7 length 256 rejected");
    put_pre(); put_sec(8'h62, 255); hdr_len = img_len;
    run(1, 1, 1'b0, 0, 1'b0, 1'b0, "R8 length 255 consumes budget");
    put_pre(); put_pay(32'h0001_2345, 3);
    run(2, 2, 1'b1, 32'h0001_2345, 1'b1, 1'b0, "R5 four-byte length");

    // R8: budget boundary pair (99 consumed vs 100 consumed)
    put_pre(); put_sec(8'h61, 40); put_sec(8'h62, 40); put_sec(8'h63, 10); put_pay(32'd6, 6);
    run(2, 1, 1'b1, 32'd6, 1'b0, 1'b0, "R8 tag read at 99 bytes");
    put_pre(); put_sec(8'h61, 40); put_sec(8'h62, 40); put_sec(8'h63, 20); put_pay(32'd6, 6);
    hdr_len = img_len;
    run(2, 1, 1'b0, 0, 1'b0, 1'b0, "R8 budget exhausted");

    // R9: zero-length payload section
    put_pre(); put_pay(32'd0, 0);
    run(3, 2, 1'b1, 32'd0, 1'b0, 1'b0, "R9 zero length");

    // R12: valid byte held during start is not taken
    good_image(5);
    run(1, 1, 1'b1, 32'd5, 1'b0, 1'b1, "R12 start collision");
    good_image(9);
    run(3, 3, 1'b1, 32'd9, 1'b1, 1'b1, "R12 start collision interleaved");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule